// File: doc/BRIEF.md
# Hashed VPI/VCI Connection Lookup

This block resolves the virtual path and virtual channel identifiers of a received ATM cell header to the pointer of that connection's reassembly table. It folds the 28-bit identifier pair into a short index and reads one hash-table word from local memory. That word gives the head of a chain of connection nodes. The block then walks the chain node by node and compares the full stored key against the search key at every node. The walk ends on a match, at a null next pointer, or when a step limit runs out.

Any identifier value can be placed in the table. The table costs one word per hash slot plus one word per configured connection, which is far less than one word for every possible identifier pair. A requester raises `start` for one cycle while the block is idle. The block drives a single-read synchronous memory port while `busy` is high. It reports the result in a one-cycle `done` pulse that carries `hit`, `err` and `conn_ptr`. Entries are written into local memory by software, outside this block.

Top module: `vphash_lookup`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `busy`, `done`, `hit`, `err` and `mem_rd` are 0.
- R2: The first memory read of a lookup uses address HASH_BASE + h. Here k = {vpi, vci} with vpi in bits 27:16, and h = k[9:0] ^ k[19:10] ^ {2'b00, k[27:20]}.
- R3: A hash-table word holds its valid flag in bit WORD_W-1 and the chain head address in bits ADDR_W-1:0. If the flag is 0 or the head is 0, the lookup ends as a miss without reading any node.
- R4: A node word is {valid (bit WORD_W-1), key[27:0], conn_ptr[CPTR_W-1:0], next[ADDR_W-1:0]}, with next in the least significant bits. A node matches only when valid is 1 and all 28 key bits equal the search key. The lookup then ends with hit=1 and conn_ptr equal to the node's pointer field.
- R5: On a mismatch the walk reads the node at the next address. A next field of 0 ends the lookup as a miss (hit=0, err=0).
- R6: A node whose valid bit is 0 never matches, even when its key is equal. The walk continues through its next field.
- R7: If MAX_STEPS nodes have been read without a match and the last of them has a nonzero next field, the lookup ends with err=1 and hit=0.
- R8: `done` is high for exactly one cycle per accepted lookup. `hit`, `err` and `conn_ptr` are 0 in every cycle without `done`, and `conn_ptr` is 0 on a miss or an error.
- R9: A `start` raised while `busy` is high is ignored. It produces no second result and does not change the lookup in progress.
- R10: `mem_rd` is high for one cycle per memory access and only while `busy`. Read data is used in the cycle after the read. A lookup that reads N nodes keeps `busy` high for 2 + 2N cycles, and `done` rises as `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a lookup with the present vpi/vci (accepted when idle) |
| vpi | input | VPI_W (12) | Virtual path identifier of the cell |
| vci | input | VCI_W (16) | Virtual channel identifier of the cell |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Connection found (valid with done) |
| err | output | 1 | Step limit reached (valid with done) |
| conn_ptr | output | CPTR_W (16) | Connection table pointer (valid with done and hit) |
| mem_rd | output | 1 | Local memory read strobe |
| mem_addr | output | ADDR_W (11) | Local memory read address |
| mem_rdata | input | WORD_W (56) | Read data, valid the cycle after mem_rd |

## Verification
The assertions assume that the memory returns data exactly one cycle after `mem_rd`. They also assume that the memory contents do not change during a lookup and that `rst_n` is the only reset. The bench models the memory as a registered array that answers only on a read strobe. It writes hash-table words and nodes only while the block is idle, and it drives `start` as single-cycle pulses. Chains that collide on one hash slot, a self-referencing node and a start issued while busy drive the walker into every exit path.

// File: rtl/lkp_pkg.sv
package lkp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_HREAD = 3'd1,
      ST_HEVAL = 3'd2,
      ST_NREAD = 3'd3,
      ST_NEVAL = 3'd4
   } walk_state_e;

   typedef enum logic [1:0] {
      RES_MISS = 2'd0,
      RES_HIT  = 2'd1,
      RES_ERR  = 2'd2
   } walk_result_e;

endpackage

// File: rtl/lkp_hash_fold.sv
module lkp_hash_fold #(
   parameter int KEY_W = 28,
   parameter int IDX_W = 10
) (
   input  logic [KEY_W-1:0] key,
   output logic [IDX_W-1:0] idx
);
   localparam int N_CHUNK = (KEY_W + IDX_W - 1) / IDX_W;
   localparam int PAD_W   = N_CHUNK * IDX_W;

   generate
      if (KEY_W <= IDX_W) begin : g_narrow
         assign idx = IDX_W'(key);
      end else begin : g_fold
         logic [PAD_W-1:0] padded;
         assign padded = PAD_W'(key);
         for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
            logic [IDX_W-1:0] part;
            if (c == 0) begin : g_first
               assign part = padded[c*IDX_W +: IDX_W];
            end else begin : g_next
               assign part = g_chunk[c-1].part ^ padded[c*IDX_W +: IDX_W];
            end
         end
         assign idx = g_chunk[N_CHUNK-1].part;
      end
   endgenerate
endmodule

// File: rtl/lkp_word_decode.sv
module lkp_word_decode #(
   parameter int KEY_W  = 28,
   parameter int CPTR_W = 16,
   parameter int ADDR_W = 11,
   parameter int WORD_W = 56
) (
   input  logic [WORD_W-1:0] word,
   input  logic [KEY_W-1:0]  search_key,
   output logic              head_ok,
   output logic [ADDR_W-1:0] head_addr,
   output logic              node_hit,
   output logic [CPTR_W-1:0] node_cptr,
   output logic [ADDR_W-1:0] node_next
);
   localparam int NEXT_LSB = 0;
   localparam int CPTR_LSB = NEXT_LSB + ADDR_W;
   localparam int KEY_LSB  = CPTR_LSB + CPTR_W;
   localparam int VLD_BIT  = WORD_W - 1;

   logic              vld;
   logic [KEY_W-1:0]  stored_key;

   assign vld        = word[VLD_BIT];
   assign stored_key = word[KEY_LSB +: KEY_W];

   // hash-table interpretation
   assign head_addr = word[NEXT_LSB +: ADDR_W];
   assign head_ok   = vld && (head_addr != '0);

   // node interpretation
   assign node_cptr = word[CPTR_LSB +: CPTR_W];
   assign node_next = word[NEXT_LSB +: ADDR_W];
   assign node_hit  = vld && (stored_key == search_key);
endmodule

// File: rtl/lkp_walk_ctrl.sv
module lkp_walk_ctrl
   import lkp_pkg::*;
#(
   parameter int KEY_W     = 28,
   parameter int IDX_W     = 10,
   parameter int CPTR_W    = 16,
   parameter int ADDR_W    = 11,
   parameter int MAX_STEPS = 32,
   parameter int HASH_BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [KEY_W-1:0]  key_in,
   input  logic [IDX_W-1:0]  idx,
   input  logic              head_ok,
   input  logic [ADDR_W-1:0] head_addr,
   input  logic              node_hit,
   input  logic [CPTR_W-1:0] node_cptr,
   input  logic [ADDR_W-1:0] node_next,
   output logic [KEY_W-1:0]  key_q,
   output logic              busy,
   output logic              done,
   output logic              hit,
   output logic              err,
   output logic [CPTR_W-1:0] conn_ptr,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr
);
   localparam int STEP_W = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(MAX_STEPS - 1);
   localparam logic [ADDR_W-1:0] BASE_A    = ADDR_W'(HASH_BASE);

   walk_state_e      state_q;
   walk_result_e     res_q;
   logic [STEP_W-1:0] steps_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CPTR_W-1:0] ptr_q;
   logic              done_q;
   logic [ADDR_W-1:0] idx_addr;

   assign idx_addr = BASE_A + {{(ADDR_W-IDX_W){1'b0}}, idx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         res_q   <= RES_MISS;
         steps_q <= '0;
         addr_q  <= '0;
         ptr_q   <= '0;
         key_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  key_q   <= key_in;
                  addr_q  <= idx_addr;
                  steps_q <= '0;
                  state_q <= ST_HREAD;
               end
            end
            ST_HREAD: state_q <= ST_HEVAL;
            ST_HEVAL: begin
               if (head_ok) begin
                  addr_q  <= head_addr;
                  state_q <= ST_NREAD;
               end else begin
                  res_q   <= RES_MISS;
                  ptr_q   <= '0;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            ST_NREAD: state_q <= ST_NEVAL;
            ST_NEVAL: begin
               if (node_hit) begin
                  res_q   <= RES_HIT;
                  ptr_q   <= node_cptr;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (node_next == '0) begin
                  res_q   <= RES_MISS;
                  ptr_q   <= '0;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else if (steps_q == LAST_STEP) begin
                  res_q   <= RES_ERR;
                  ptr_q   <= '0;
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  steps_q <= steps_q + 1'b1;
                  addr_q  <= node_next;
                  state_q <= ST_NREAD;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign mem_rd   = (state_q == ST_HREAD) || (state_q == ST_NREAD);
   assign mem_addr = addr_q;
   assign done     = done_q;
   assign hit      = done_q && (res_q == RES_HIT);
   assign err      = done_q && (res_q == RES_ERR);
   assign conn_ptr = done_q ? ptr_q : '0;
endmodule

// File: rtl/vphash_lookup.sv
module vphash_lookup #(
   parameter int VPI_W     = 12,
   parameter int VCI_W     = 16,
   parameter int IDX_W     = 10,
   parameter int ADDR_W    = 11,
   parameter int CPTR_W    = 16,
   parameter int WORD_W    = 56,
   parameter int MAX_STEPS = 32,
   parameter int HASH_BASE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VPI_W-1:0]  vpi,
   input  logic [VCI_W-1:0]  vci,
   output logic              busy,
   output logic              done,
   output logic              hit,
   output logic              err,
   output logic [CPTR_W-1:0] conn_ptr,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [WORD_W-1:0] mem_rdata
);
   localparam int KEY_W = VPI_W + VCI_W;

   generate
      if (WORD_W != 1 + KEY_W + CPTR_W + ADDR_W) begin : g_bad_word
         $error("WORD_W must equal 1 + VPI_W + VCI_W + CPTR_W + ADDR_W");
      end
      if (IDX_W >= ADDR_W) begin : g_bad_idx
         $error("IDX_W must be narrower than ADDR_W");
      end
      if (HASH_BASE < 0 || HASH_BASE + (1 << IDX_W) > (1 << ADDR_W)) begin : g_bad_base
         $error("hash table does not fit in the address space");
      end
      if (MAX_STEPS < 1) begin : g_bad_steps
         $error("MAX_STEPS must be at least 1");
      end
   endgenerate

   logic [KEY_W-1:0]  key_in;
   logic [KEY_W-1:0]  key_q;
   logic [IDX_W-1:0]  idx;
   logic              head_ok;
   logic [ADDR_W-1:0] head_addr;
   logic              node_hit;
   logic [CPTR_W-1:0] node_cptr;
   logic [ADDR_W-1:0] node_next;

   assign key_in = {vpi, vci};

   lkp_hash_fold #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash (
      .key (key_in),
      .idx (idx)
   );

   lkp_word_decode #(
      .KEY_W(KEY_W), .CPTR_W(CPTR_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
   ) u_dec (
      .word       (mem_rdata),
      .search_key (key_q),
      .head_ok    (head_ok),
      .head_addr  (head_addr),
      .node_hit   (node_hit),
      .node_cptr  (node_cptr),
      .node_next  (node_next)
   );

   lkp_walk_ctrl #(
      .KEY_W(KEY_W), .IDX_W(IDX_W), .CPTR_W(CPTR_W), .ADDR_W(ADDR_W),
      .MAX_STEPS(MAX_STEPS), .HASH_BASE(HASH_BASE)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .key_in    (key_in),
      .idx       (idx),
      .head_ok   (head_ok),
      .head_addr (head_addr),
      .node_hit  (node_hit),
      .node_cptr (node_cptr),
      .node_next (node_next),
      .key_q     (key_q),
      .busy      (busy),
      .done      (done),
      .hit       (hit),
      .err       (err),
      .conn_ptr  (conn_ptr),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr)
   );
endmodule

// File: rtl/lkp_checker.sv
module lkp_checker #(
   parameter int KEY_W     = 28,
   parameter int CPTR_W    = 16,
   parameter int MAX_STEPS = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              hit,
   input logic              err,
   input logic [CPTR_W-1:0] conn_ptr,
   input logic              mem_rd,
   input logic [KEY_W-1:0]  key_q
);
   localparam int BUSY_LIMIT = 2 * MAX_STEPS + 2;

   logic [31:0] busy_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + 1'b1;
      else           busy_cnt <= '0;
   end

   assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= 32'(BUSY_LIMIT));

   assert_err_not_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !hit);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_quiet_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!hit && !err && conn_ptr == '0));

   assert_miss_ptr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !hit) |-> conn_ptr == '0);

   assert_key_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(key_q));

   assert_rd_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> busy);

   assert_rd_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(busy));
endmodule

bind vphash_lookup lkp_checker #(
   .KEY_W(KEY_W), .CPTR_W(CPTR_W), .MAX_STEPS(MAX_STEPS)
) u_lkp_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .hit      (hit),
   .err      (err),
   .conn_ptr (conn_ptr),
   .mem_rd   (mem_rd),
   .key_q    (key_q)
);

// File: tb/tb_vphash_lookup.sv
module tb_vphash_lookup;
   localparam int VPI_W = 12, VCI_W = 16, IDX_W = 10, ADDR_W = 11;
   localparam int CPTR_W = 16, WORD_W = 56, MAX_STEPS = 32, HASH_BASE = 0;
   localparam int DEPTH = 1 << ADDR_W;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [VPI_W-1:0] vpi = '0;
   logic [VCI_W-1:0] vci = '0;
   logic busy, done, hit, err, mem_rd;
   logic [CPTR_W-1:0] conn_ptr;
   logic [ADDR_W-1:0] mem_addr;
   logic [WORD_W-1:0] mem_rdata = '0;
   logic [WORD_W-1:0] mem [DEPTH];

   int n_run = 0, n_fail = 0, n_done = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   vphash_lookup dut (
      .clk(clk), .rst_n(rst_n), .start(start), .vpi(vpi), .vci(vci),
      .busy(busy), .done(done), .hit(hit), .err(err), .conn_ptr(conn_ptr),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

   typedef struct {
      string            req;
      bit               hit;
      bit               err;
      logic [CPTR_W-1:0] ptr;
      logic [ADDR_W-1:0] addr;
      int               busy_cycles;
   } exp_t;
   exp_t exp_q[$];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [IDX_W-1:0] hash_of(input logic [11:0] p, input logic [15:0] c);
      logic [27:0] k;
      k = {p, c};
      return k[9:0] ^ k[19:10] ^ {2'b00, k[27:20]};
   endfunction

   task automatic put_node(input int a, input bit v, input logic [11:0] p,
                           input logic [15:0] c, input logic [15:0] cp, input int nx);
      mem[a] = {v, p, c, cp, ADDR_W'(nx)};
   endtask

   task automatic put_head(input logic [11:0] p, input logic [15:0] c, input bit v, input int h);
      mem[HASH_BASE + int'(hash_of(p, c))] = {v, 44'b0, ADDR_W'(h)};
   endtask

   // monitor
   bit seen_rd = 1'b0;
   int busy_cnt = 0;
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (busy) busy_cnt++;
         if (mem_rd && !seen_rd) begin
            seen_rd = 1'b1;
            if (exp_q.size() != 0)
               check(mem_addr == exp_q[0].addr, "R2", "hash read address", mem_addr, exp_q[0].addr);
         end
         if (!done && (hit || err || conn_ptr != '0))
            check(1'b0, "R8", "outputs outside done", {hit, err, conn_ptr}, 0);
         if (done) begin
            n_done++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(hit == e.hit, e.req, "hit", hit, e.hit);
               check(err == e.err, e.req, "err", err, e.err);
               check(conn_ptr == e.ptr, e.req, "conn_ptr", conn_ptr, e.ptr);
               check(busy_cnt == e.busy_cycles, "R10", "busy cycles", busy_cnt, e.busy_cycles);
            end
            busy_cnt = 0;
            seen_rd = 1'b0;
         end
      end
   end

   task automatic push(input string req, input logic [11:0] p, input logic [15:0] c,
                       input bit h, input bit e, input logic [15:0] cp, input int nodes);
      exp_t x;
      x.req = req; x.hit = h; x.err = e; x.ptr = cp;
      x.addr = ADDR_W'(HASH_BASE) + ADDR_W'(hash_of(p, c));
      x.busy_cycles = 2 + 2 * nodes;
      exp_q.push_back(x);
   endtask

   task automatic pulse(input logic [11:0] p, input logic [15:0] c);
      @(negedge clk);
      vpi = p; vci = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      do @(posedge clk); while (exp_q.size() != 0);
      @(negedge clk);
   endtask

   task automatic lookup(input string req, input logic [11:0] p, input logic [15:0] c,
                         input bit h, input bit e, input logic [15:0] cp, input int nodes);
      push(req, p, c, h, e, cp, nodes);
      pulse(p, c);
      wait_idle();
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         check(1'b0, "watchdog", "timeout", 1, 0);
         summary();
      end
   end

   initial begin
      int d0;
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;

      // R1: reset state
      repeat (3) @(negedge clk);
      check({busy, done, hit, err, mem_rd} == 5'b0, "R1", "outputs in reset", {busy, done, hit, err, mem_rd}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({busy, done, hit, err, mem_rd} == 5'b0, "R1", "outputs after reset", {busy, done, hit, err, mem_rd}, 0);

      // R3: empty hash entry, then valid entry with null head
      lookup("R3", 12'd1, 16'd100, 0, 0, 16'h0, 0);
      put_head(12'd2, 16'd200, 1'b1, 0);
      lookup("R3", 12'd2, 16'd200, 0, 0, 16'h0, 0);

      // R4: single node hit
      put_node(1024, 1'b1, 12'd3, 16'h0300, 16'hA5A5, 0);
      put_head(12'd3, 16'h0300, 1'b1, 1024);
      lookup("R4", 12'd3, 16'h0300, 1, 0, 16'hA5A5, 1);

      // R5: three colliding keys in one chain
      put_node(1030, 1'b1, 12'd0, 16'h0005, 16'h1111, 1031);
      put_node(1031, 1'b1, 12'd0, 16'h0404, 16'h2222, 1032);
      put_node(1032, 1'b1, 12'd0, 16'h0807, 16'h3333, 0);
      put_head(12'd0, 16'h0005, 1'b1, 1030);
      lookup("R5", 12'd0, 16'h0807, 1, 0, 16'h3333, 3);
      lookup("R5", 12'd0, 16'h0005, 1, 0, 16'h1111, 1);
      lookup("R5", 12'd0, 16'h0404, 1, 0, 16'h2222, 2);
      lookup("R5", 12'd0, 16'h1001, 0, 0, 16'h0, 3);
      // R4: same hash, key differs only in high vpi bit and one vci bit
      lookup("R4", 12'h800, 16'h0085, 0, 0, 16'h0, 3);

      // R6: invalid node with equal key is skipped
      put_node(1040, 1'b0, 12'd4, 16'h0050, 16'hDEAD, 1041);
      put_node(1041, 1'b1, 12'd4, 16'h0050, 16'hBEEF, 0);
      put_head(12'd4, 16'h0050, 1'b1, 1040);
      lookup("R6", 12'd4, 16'h0050, 1, 0, 16'hBEEF, 2);

      // R7: self loop hits the step limit
      put_node(1050, 1'b1, 12'd5, 16'h0124, 16'h7777, 1050);
      put_head(12'd5, 16'h0123, 1'b1, 1050);
      lookup("R7", 12'd5, 16'h0123, 0, 1, 16'h0, MAX_STEPS);

      // R9: start during busy is ignored
      d0 = n_done;
      push("R9", 12'd0, 16'h0807, 1, 0, 16'h3333, 3);
      pulse(12'd0, 16'h0807);
      @(negedge clk);
      check(busy == 1'b1, "R9", "busy before second start", busy, 1);
      vpi = 12'd3; vci = 16'h0300; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      repeat (10) @(negedge clk);
      check(n_done == d0 + 1, "R9", "done count", n_done - d0, 1);
      check(busy == 1'b0, "R9", "idle after ignored start", busy, 0);

      // back-to-back lookups after R9
      lookup("R4", 12'd3, 16'h0300, 1, 0, 16'hA5A5, 1);
      check(mem_rd == 1'b0, "R10", "no read while idle", mem_rd, 0);

      finished = 1'b1;
      summary();
   end
endmodule